// File: doc/BRIEF.md
# BCD Calendar Clock with Time-of-Day Alarm

This block keeps wall-clock time and date in binary-coded decimal. The registers cover seconds, minutes, hours, day of week, date, month and a two-digit year. The base rate comes from an external `tick` strobe. A built-in phase counter turns every `TICKS_PER_SEC` strobes into one second. The hours field runs in either 24-hour mode or 12-hour mode with an AM/PM flag. The calendar gives each month its correct length, and February gets 29 days in every year divisible by four, including year 00.

A four-field alarm checks seconds, minutes, hours and day of week against the live time once per second, right after the time has advanced. Bit 7 of each alarm field is a "don't care" mask, so one set of registers can produce an alarm every second, every minute, every hour, every day or once a week. A match raises a sticky flag, and the flag drives the interrupt output when interrupts are enabled.

Software uses a synchronous single-cycle register port. A write takes effect on the clock edge where `wr_en` is high. Read data is registered and appears on the cycle after `rd_en`. Two control bits matter most: a halt bit that freezes timekeeping and a write-lock bit that protects every register except the control register.

Top module: `bcd_rtc_core`

## Requirements
- R1: After `rst`, the registers read as follows. Time reads 00:00:00 in 24-hour mode, day-of-week 01, date 01, month 01, year 00. All alarm fields read 00. Control (address 0xB) reads 0x80, meaning halt=1, write-lock=0 and interrupt enable=0. Status (address 0xC) reads 0x00 and `irq` is 0.
- R2: The register map is as follows.
  - Address 0: seconds (7 bits).
  - Address 1: minutes (7 bits).
  - Address 2: hours (7 bits).
  - Address 3: day of week (3 bits).
  - Address 4: date (6 bits).
  - Address 5: month (5 bits).
  - Address 6: year (8 bits).
  - Addresses 7 to 0xA: alarm seconds, minutes, hours and day. Bit 7 is the mask. The remaining bits follow the width of the matching time field.
  - Address 0xB: control. Bit 7 is halt, bit 6 is write-lock, bit 0 is interrupt enable.
  - Address 0xC: status. Bit 0 is the alarm flag.
  - Unused bits, and addresses 0xD to 0xF, always read 0.
  - `rdata` is valid one cycle after `rd_en`.
- R3: While control bit 7 is 0, every `TICKS_PER_SEC`-th `tick` advances the time by one second. While control bit 7 is 1, the time does not change.
- R4: A write to any time register (addresses 0 to 6) loads that field and restarts the sub-second phase. A full `TICKS_PER_SEC` ticks are then needed before the next second.
- R5: The seconds and minutes fields count in BCD from 00 to 59 and wrap to 00, carrying into the next field. In 24-hour mode (hours bit 6 = 0), hours count 00 to 23 and wrap to 00 with a carry into the day.
- R6: In 12-hour mode (hours bit 6 = 1), hours bits 4:0 count 12, 01, …, 11 in BCD and bit 5 is PM. Going from 11 to 12 toggles PM. Going from 11 PM to 12 AM carries into the day.
- R7: Dates wrap after the last day of the month. Month 02 has 29 days when the BCD year is divisible by 4, which includes 00, and 28 days otherwise. Months 04, 06, 09 and 11 have 30 days, and all other months have 31. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R8: On each day carry, day of week counts 1 to 7 and wraps from 7 to 1.
- R9: An alarm match happens on a second update when every alarm field either has bit 7 set or equals its time field. Seconds, minutes and hours compare their low 7 bits, and day compares bits 2:0.
- R10: A match sets status bit 0 one cycle after the second update. `irq` is a registered output. It is 1 exactly when, on the previous cycle, status bit 0 and control bit 0 were both 1.
- R11: Any read or write at addresses 7 to 0xA clears status bit 0. If a new match arrives in the same cycle, the match wins.
- R12: While control bit 6 is 1, writes to addresses 0 to 0xA have no effect. The control register stays writable at all times. Writes to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sub-second time-base strobe, one cycle per pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered alarm interrupt, active high |

## Verification
The hardest cases to reach are the chained carries: 11:59:59 PM into the next day, the last day of February in leap and non-leap years, and year 99 into year 00. From reset each of these would take a huge number of seconds. The stimulus avoids this by writing the time fields to one second before the boundary and then giving exactly `TICKS_PER_SEC` ticks. The same preload approach sets up a full no-mask alarm on a day boundary. Once near the boundary, the flag and the interrupt are checked at the cycles where they first become visible.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam int unsigned N_TIME = 7;
  localparam int unsigned N_ALARM = 4;

  localparam logic [AW-1:0] AD_SEC   = 4'h0;
  localparam logic [AW-1:0] AD_YEAR  = 4'h6;
  localparam logic [AW-1:0] AD_ASEC  = 4'h7;
  localparam logic [AW-1:0] AD_ADOW  = 4'hA;
  localparam logic [AW-1:0] AD_CTRL  = 4'hB;
  localparam logic [AW-1:0] AD_STAT  = 4'hC;

  // storage mask of each time field (index = address)
  function automatic logic [DW-1:0] time_mask(input int unsigned idx);
    case (idx)
      0, 1, 2: return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // compare mask of each alarm field (bit 7 is the don't-care flag)
  function automatic logic [DW-1:0] alarm_cmp_mask(input int unsigned idx);
    return (idx == 3) ? 8'h07 : 8'h7F;
  endfunction

  function automatic logic [DW-1:0] bcd_inc(input logic [DW-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // BCD year divisible by four
  function automatic logic bcd_leap(input logic [DW-1:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [DW-1:0] last_date(input logic [DW-1:0] m, input logic [DW-1:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       run,
  input  logic                       wr_en,
  input  logic [AW-1:0]              waddr,
  input  logic [DW-1:0]              wdata,
  output logic [N_TIME-1:0][DW-1:0]  tm,
  output logic                       sec_evt
);
  localparam int unsigned PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0]             phase;
  logic                      time_wr;
  logic [N_TIME-1:0][DW-1:0] nxt;
  logic                      c_min, c_hr, c_day, c_mon, c_yr;
  logic [DW-1:0]             hinc;

  assign time_wr = wr_en && (waddr <= AD_YEAR);
  assign sec_evt = tick && run && !time_wr && (phase == PH_LAST);

  always_comb begin
    nxt   = tm;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    hinc  = bcd_inc({3'b000, tm[2][4:0]});
    c_min = (tm[0] == 8'h59);
    c_hr  = c_min && (tm[1] == 8'h59);
    nxt[0] = c_min ? 8'h00 : bcd_inc(tm[0]);
    if (c_min) nxt[1] = c_hr ? 8'h00 : bcd_inc(tm[1]);
    if (c_hr) begin
      if (tm[2][6]) begin
        if (tm[2][4:0] == 5'h11) begin
          nxt[2] = {2'b01, ~tm[2][5], 5'h12};
          c_day  = tm[2][5];
        end else if (tm[2][4:0] == 5'h12) begin
          nxt[2] = {2'b01, tm[2][5], 5'h01};
        end else begin
          nxt[2] = {2'b01, tm[2][5], hinc[4:0]};
        end
      end else if (tm[2][5:0] == 6'h23) begin
        nxt[2] = 8'h00;
        c_day  = 1'b1;
      end else begin
        nxt[2] = bcd_inc(tm[2]);
      end
    end
    if (c_day) begin
      nxt[3] = (tm[3] == 8'h07) ? 8'h01 : tm[3] + 8'h01;
      c_mon  = (tm[4] == last_date(tm[5], tm[6]));
      nxt[4] = c_mon ? 8'h01 : bcd_inc(tm[4]);
    end
    if (c_mon) begin
      c_yr   = (tm[5] == 8'h12);
      nxt[5] = c_yr ? 8'h01 : bcd_inc(tm[5]);
    end
    if (c_yr) nxt[6] = (tm[6] == 8'h99) ? 8'h00 : bcd_inc(tm[6]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tm    <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      phase <= '0;
    end else if (time_wr) begin
      tm[waddr[2:0]] <= wdata & time_mask(int'(waddr));
      phase          <= '0;
    end else begin
      if (tick && run) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (sec_evt) tm <= nxt;
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        acc,
  input  logic [AW-1:0]               waddr,
  input  logic [DW-1:0]               wdata,
  input  logic [N_ALARM-1:0][DW-1:0]  now,
  input  logic                        upd,
  output logic [N_ALARM-1:0][DW-1:0]  al,
  output logic                        irqf
);
  logic [N_ALARM-1:0] fmatch;
  logic [AW-1:0]      off;

  assign off = waddr - AD_ASEC;

  for (genvar i = 0; i < N_ALARM; i++) begin : g_field
    localparam logic [DW-1:0] CMP = alarm_cmp_mask(i);
    always_ff @(posedge clk) begin
      if (rst) al[i] <= '0;
      else if (wr_en && (off == AW'(i))) al[i] <= wdata & (CMP | 8'h80);
    end
    assign fmatch[i] = al[i][7] || ((al[i] & CMP) == (now[i] & CMP));
  end

  always_ff @(posedge clk) begin
    if (rst) irqf <= 1'b0;
    else if (upd && (&fmatch)) irqf <= 1'b1;
    else if (acc) irqf <= 1'b0;
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [3:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);
  logic                       halt, wp, aie;
  logic                       wr_ok, al_sel, sec_evt, sec_evt_d, irqf;
  logic [N_TIME-1:0][DW-1:0]  tm;
  logic [N_ALARM-1:0][DW-1:0] al;
  logic [AW-1:0]              aoff;

  assign wr_ok  = wr_en && !wp;
  assign al_sel = (addr >= AD_ASEC) && (addr <= AD_ADOW);
  assign aoff   = addr - AD_ASEC;

  rtc_timekeep #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_time (
    .clk(clk), .rst(rst), .tick(tick), .run(!halt),
    .wr_en(wr_ok), .waddr(addr), .wdata(wdata),
    .tm(tm), .sec_evt(sec_evt)
  );

  rtc_alarm u_alarm (
    .clk(clk), .rst(rst), .wr_en(wr_ok && al_sel), .acc((wr_en || rd_en) && al_sel),
    .waddr(addr), .wdata(wdata), .now(tm[3:0]), .upd(sec_evt_d),
    .al(al), .irqf(irqf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halt      <= 1'b1;
      wp        <= 1'b0;
      aie       <= 1'b0;
      sec_evt_d <= 1'b0;
      irq       <= 1'b0;
      rdata     <= '0;
    end else begin
      sec_evt_d <= sec_evt;
      irq       <= irqf && aie;
      if (wr_en && addr == AD_CTRL) begin
        halt <= wdata[7];
        wp   <= wdata[6];
        aie  <= wdata[0];
      end
      if (rd_en) begin
        if (addr <= AD_YEAR)     rdata <= tm[addr[2:0]];
        else if (al_sel)         rdata <= al[aoff[1:0]];
        else if (addr == AD_CTRL) rdata <= {halt, wp, 5'b0, aie};
        else if (addr == AD_STAT) rdata <= {7'b0, irqf};
        else                     rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       irqf,
  input logic       aie,
  input logic       halt,
  input logic       wp,
  input logic       upd,
  input logic [7:0] t_sec,
  input logic [7:0] a_sec
);
  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irqf && aie)) else $error("irq"); // R10
  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (halt && !wr_en) |=> $stable(t_sec)) else $error("halt"); // R3
  AST_LOCK_ALARM: assert property (@(posedge clk) disable iff (rst)
    (wp && wr_en && addr == 4'h7) |=> $stable(a_sec)) else $error("lock"); // R12
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && addr >= 4'h7 && addr <= 4'hA && !upd) |=> !irqf) else $error("clr"); // R11
  AST_EMPTY_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= 4'hD) |=> rdata == 8'h00) else $error("empty"); // R2
endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq(irq), .irqf(irqf), .aie(aie), .halt(halt), .wp(wp), .upd(sec_evt_d),
  .t_sec(tm[0]), .a_sec(al[0])
);

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
  localparam int TPS = 4;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int total = 0, fails = 0;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'h2, h); wr(4'h1, m); wr(4'h0, s);
  endtask

  task automatic t_reset;
    rd_chk("R1 sec", 4'h0, 8'h00); rd_chk("R1 hour", 4'h2, 8'h00);
    rd_chk("R1 dow", 4'h3, 8'h01); rd_chk("R1 date", 4'h4, 8'h01);
    rd_chk("R1 month", 4'h5, 8'h01); rd_chk("R1 year", 4'h6, 8'h00);
    rd_chk("R1 alarm", 4'h9, 8'h00);
    rd_chk("R1 ctrl", 4'hB, 8'h80); rd_chk("R1 status", 4'hC, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_halt;
    ticks(TPS); rd_chk("R3 halted", 4'h0, 8'h00);
    wr(4'hB, 8'h00); ticks(TPS); rd_chk("R3 running", 4'h0, 8'h01);
  endtask

  task automatic t_map;
    wr(4'h0, 8'hFF); rd_chk("R2 sec bits", 4'h0, 8'h7F);
    wr(4'h3, 8'hFF); rd_chk("R2 dow bits", 4'h3, 8'h07);
    wr(4'h4, 8'hFF); rd_chk("R2 date bits", 4'h4, 8'h3F);
    rd_chk("R2 empty addr", 4'hE, 8'h00);
    wr(4'hC, 8'hFF); rd_chk("R12 status write ignored", 4'hC, 8'h00);
    wr(4'hB, 8'hFF); rd_chk("R2 ctrl bits", 4'hB, 8'hC1);
    wr(4'hB, 8'h00);
  endtask

  task automatic t_phase;
    wr(4'h0, 8'h10); ticks(2); wr(4'h0, 8'h20); ticks(TPS - 1);
    rd_chk("R4 phase restart", 4'h0, 8'h20);
    ticks(1); rd_chk("R4 full second", 4'h0, 8'h21);
  endtask

  task automatic t_rollover;
    wr(4'h3, 8'h07); wr(4'h4, 8'h31); wr(4'h5, 8'h12); wr(4'h6, 8'h99);
    set_hms(8'h23, 8'h59, 8'h59); ticks(TPS);
    rd_chk("R5 sec wrap", 4'h0, 8'h00); rd_chk("R5 min wrap", 4'h1, 8'h00);
    rd_chk("R5 hour wrap", 4'h2, 8'h00); rd_chk("R8 dow wrap", 4'h3, 8'h01);
    rd_chk("R7 date wrap", 4'h4, 8'h01); rd_chk("R7 month wrap", 4'h5, 8'h01);
    rd_chk("R7 year wrap", 4'h6, 8'h00);
    set_hms(8'h09, 8'h09, 8'h39); ticks(TPS);
    rd_chk("R5 bcd digit carry", 4'h0, 8'h40);
  endtask

  task automatic feb(input string req, input logic [7:0] y, input logic [7:0] m,
                     input logic [7:0] d, input logic [7:0] ed, input logic [7:0] em);
    wr(4'h6, y); wr(4'h5, m); wr(4'h4, d); set_hms(8'h23, 8'h59, 8'h59); ticks(TPS);
    rd_chk(req, 4'h4, ed); rd_chk(req, 4'h5, em);
  endtask

  task automatic t_calendar;
    feb("R7 leap 24", 8'h24, 8'h02, 8'h28, 8'h29, 8'h02);
    feb("R7 leap end", 8'h24, 8'h02, 8'h29, 8'h01, 8'h03);
    feb("R7 common 23", 8'h23, 8'h02, 8'h28, 8'h01, 8'h03);
    feb("R7 year 00", 8'h00, 8'h02, 8'h28, 8'h29, 8'h02);
    feb("R7 april", 8'h23, 8'h04, 8'h30, 8'h01, 8'h05);
  endtask

  task automatic t_12h;
    wr(4'h3, 8'h03); set_hms(8'h71, 8'h59, 8'h59); ticks(TPS);
    rd_chk("R6 11PM to 12AM", 4'h2, 8'h52); rd_chk("R6 day carry", 4'h3, 8'h04);
    set_hms(8'h51, 8'h59, 8'h59); ticks(TPS);
    rd_chk("R6 11AM to 12PM", 4'h2, 8'h72); rd_chk("R6 no day carry", 4'h3, 8'h04);
    set_hms(8'h72, 8'h59, 8'h59); ticks(TPS);
    rd_chk("R6 12 to 1", 4'h2, 8'h61);
  endtask

  task automatic t_alarm;
    set_hms(8'h10, 8'h00, 8'h00);
    wr(4'h7, 8'h80); wr(4'h8, 8'h80); wr(4'h9, 8'h80); wr(4'hA, 8'h80);
    ticks(TPS);
    rd_chk("R9 all masked", 4'hC, 8'h01);
    chk("R10 irq disabled", {7'b0, irq}, 8'h00);
    rd_chk("R11 read alarm", 4'h7, 8'h80);
    rd_chk("R11 flag cleared", 4'hC, 8'h00);
    wr(4'hB, 8'h01); ticks(TPS);
    chk("R10 irq enabled", {7'b0, irq}, 8'h01);
    wr(4'h7, 8'h25); wr(4'h0, 8'h23); repeat (2) @(negedge clk);
    chk("R10 irq follows clear", {7'b0, irq}, 8'h00);
    ticks(TPS); rd_chk("R9 seconds differ", 4'hC, 8'h00);
    ticks(TPS); rd_chk("R9 seconds match", 4'hC, 8'h01);
    chk("R10 irq on match", {7'b0, irq}, 8'h01);
    rd_chk("R11 read alarm min", 4'h8, 8'h80);
    rd_chk("R11 cleared again", 4'hC, 8'h00);
    wr(4'h7, 8'h00); wr(4'h8, 8'h00); wr(4'h9, 8'h00); wr(4'hA, 8'h02);
    wr(4'h3, 8'h02); set_hms(8'h23, 8'h59, 8'h59); ticks(TPS);
    rd_chk("R9 day differs", 4'hC, 8'h00);
    wr(4'h3, 8'h01); set_hms(8'h23, 8'h59, 8'h59); ticks(TPS);
    rd_chk("R9 full match", 4'hC, 8'h01);
    wr(4'hB, 8'h00);
  endtask

  task automatic t_lock;
    wr(4'h0, 8'h11); wr(4'h7, 8'h33);
    wr(4'hB, 8'h40); wr(4'h0, 8'h30); wr(4'h7, 8'h44);
    rd_chk("R12 time locked", 4'h0, 8'h11);
    rd_chk("R12 alarm locked", 4'h7, 8'h33);
    wr(4'hB, 8'h00); rd_chk("R12 ctrl writable", 4'hB, 8'h00);
    wr(4'h0, 8'h30); rd_chk("R12 unlocked", 4'h0, 8'h30);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_halt();
    t_map();
    t_phase();
    t_rollover();
    t_calendar();
    t_12h();
    t_alarm();
    t_lock();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule